// File: doc/BRIEF.md
# Sequential Binary64 Multiplier Core

This block multiplies two IEEE-754 binary64 operands over several clock cycles and hands its result to a later rounding stage. It does not round, and it does not resolve overflow or underflow. A start pulse captures both operands and the invalid-trap enable. The block then does one of two things. If an operand is a NaN, an infinity or a zero, it returns a complete 64-bit special result. Otherwise it returns a sign, a working exponent, a 53-bit mantissa with its leading one in the hidden position, and a guard bit and a sticky bit for the rounding stage.

Subnormal inputs are normalized one bit per cycle before the product is formed. The product is formed by a shift-and-add loop that consumes four multiplier bits per step. Bits that fall off the bottom of the accumulator are merged into the sticky bit. A final normalization places the leading one, after which the guard and sticky bits are extracted. Quiet and signaling NaNs are told apart by fraction bit 51: a 1 there means quiet.

Top module: `dmul_seq`

## Requirements
- R1: The `sign_o` output is the XOR of operand sign bits (bit 63). This holds for finite products, for infinity results and for zero results.
- R2: Infinity times zero is invalid in either operand order. With the trap disabled, the result is special and `special_val` = 0x7FF8000000000000. `inv_flag` is 1 and `inv_trap` is 0.
- R3: Any invalid case with `trap_en` set gives `inv_trap` = 1, `inv_flag` = 0, `is_special` = 1 and `special_val` = 0.
- R4: NaN results follow a fixed priority. First, a signaling operand A is returned with bit 51 set and the invalid flag raised. Next, a signaling operand B is returned the same way. Next, a quiet operand A is returned unchanged. Finally, a NaN operand B is returned, quieted. Sign and payload are kept in every case.
- R5: Infinity times a non-NaN nonzero value returns a signed infinity. A zero operand paired with a finite value returns a signed zero. Neither case raises invalid, and a special result reads zero on `exp_o`, `mant_o`, `guard_o` and `sticky_o`.
- R6: For finite nonzero operands, `exp_o` equals the sum of both biased exponents minus 1023, plus 1 when the mantissa product is 2 or more. `mant_o` bit 52 is always 1.
- R7: A subnormal operand (exponent field 0, fraction nonzero) counts as exponent field 1. The fraction is shifted left until bit 52 is set, and the working exponent drops by one for each shift.
- R8: `mant_o` holds the top 53 bits of the exact normalized product. `guard_o` is the next bit down. `sticky_o` is the OR of all bits below the guard bit.
- R9: A start pulse is taken only while `busy` is low. Start is ignored while busy. `done` is high for exactly one cycle, and `busy` falls at the same edge at which `done` rises.
- R10: A special result raises `done` at the first rising edge after the one that samples start. Two normal operands raise `done` at the 18th rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; operands are captured at this edge |
| trap_en | input | 1 | Invalid-trap enable, captured with start |
| opa | input | 64 | Operand A (binary64) |
| opb | input | 64 | Operand B (binary64) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; all result outputs valid |
| is_special | output | 1 | Result is the finished value on `special_val` |
| special_val | output | 64 | Finished NaN, infinity or zero result |
| inv_flag | output | 1 | Invalid operation, trap disabled |
| inv_trap | output | 1 | Invalid operation, trap enabled, no result |
| sign_o | output | 1 | Product sign |
| exp_o | output | 14 | Signed working exponent, biased |
| mant_o | output | 53 | Normalized mantissa, hidden bit at 52 |
| guard_o | output | 1 | First bit below the mantissa |
| sticky_o | output | 1 | OR of all lower bits |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent and a 52-bit fraction, the binary64 format. These defaults make the loop run its full 14 four-bit steps. They also bring the extreme subnormal case into reach, where a single set fraction bit needs 52 normalizing shifts, and they let a 106-bit reference product in the bench check guard and sticky exactly. The chosen operands cover both product ranges (below 2 and at least 2) and every branch of the NaN priority. The bench also starts a second operation while one is in progress and confirms that the first operation's result is unchanged.

// File: rtl/dmul_seq.sv
module dmul_seq #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 trap_en,
  input  logic [EW+FW:0]       opa,
  input  logic [EW+FW:0]       opb,
  output logic                 busy,
  output logic                 done,
  output logic                 is_special,
  output logic [EW+FW:0]       special_val,
  output logic                 inv_flag,
  output logic                 inv_trap,
  output logic                 sign_o,
  output logic signed [EW+2:0] exp_o,
  output logic [FW:0]          mant_o,
  output logic                 guard_o,
  output logic                 sticky_o
);
  localparam int WW    = 1 + EW + FW;
  localparam int MW    = FW + 1;
  localparam int STEPS = (MW + 3) / 4;
  localparam int PW    = 4 * STEPS;
  localparam int GB    = 7;
  localparam int LEAD  = MW + GB;
  localparam int AW    = LEAD + 4;
  localparam int XW    = EW + 3;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int BIAS  = (1 << (EW - 1)) - 1;

  typedef enum logic [2:0] {S_IDLE, S_CLASS, S_NORM, S_MUL, S_ADJ, S_FIN} st_t;

  st_t                 st;
  logic [WW-1:0]       a_q, b_q;
  logic                trap_q;
  logic [MW-1:0]       ma, mb;
  logic [AW-1:0]       mc, acc, addend;
  logic [PW-1:0]       mp;
  logic                stk;
  logic signed [XW-1:0] xe;
  logic [CW-1:0]       cnt;

  wire [EW-1:0] ea = a_q[WW-2:FW];
  wire [EW-1:0] eb = b_q[WW-2:FW];
  wire [FW-1:0] fa = a_q[FW-1:0];
  wire [FW-1:0] fb = b_q[FW-1:0];
  wire sgn    = a_q[WW-1] ^ b_q[WW-1];
  wire a_max  = &ea;
  wire b_max  = &eb;
  wire a_nan  = a_max & (|fa);
  wire b_nan  = b_max & (|fb);
  wire a_inf  = a_max & ~(|fa);
  wire b_inf  = b_max & ~(|fb);
  wire a_snan = a_nan & ~fa[FW-1];
  wire b_snan = b_nan & ~fb[FW-1];
  wire a_zero = ~(|a_q[WW-2:0]);
  wire b_zero = ~(|b_q[WW-2:0]);
  wire [WW-1:0] qa   = a_q | (WW'(1) << (FW - 1));
  wire [WW-1:0] qb   = b_q | (WW'(1) << (FW - 1));
  wire [WW-1:0] qnan = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  wire [WW-1:0] infv = {sgn, {EW{1'b1}}, {FW{1'b0}}};
  wire [WW-1:0] zerv = {sgn, {(WW-1){1'b0}}};

  logic          spec, sinv;
  logic [WW-1:0] sval;

  always_comb begin
    spec = 1'b1;
    sinv = 1'b0;
    sval = '0;
    if (a_nan) begin
      if (a_snan) begin sinv = 1'b1; sval = qa; end
      else if (b_snan) begin sinv = 1'b1; sval = qb; end
      else sval = a_q;
    end else if (a_inf) begin
      if (b_nan) begin sinv = b_snan; sval = qb; end
      else if (b_zero) begin sinv = 1'b1; sval = qnan; end
      else sval = infv;
    end else if (b_nan) begin
      sinv = b_snan;
      sval = qb;
    end else if (b_inf) begin
      if (a_zero) begin sinv = 1'b1; sval = qnan; end
      else sval = infv;
    end else if (a_zero || b_zero) begin
      sval = zerv;
    end else begin
      spec = 1'b0;
    end
  end

  always_comb begin
    addend = '0;
    for (int i = 0; i < 4; i++)
      if (mp[i]) addend = addend + (mc << i);
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_q <= '0; b_q <= '0; trap_q <= 1'b0;
      ma <= '0; mb <= '0; mc <= '0; mp <= '0; acc <= '0;
      stk <= 1'b0; xe <= '0; cnt <= '0;
      done <= 1'b0; is_special <= 1'b0; special_val <= '0;
      inv_flag <= 1'b0; inv_trap <= 1'b0; sign_o <= 1'b0;
      exp_o <= '0; mant_o <= '0; guard_o <= 1'b0; sticky_o <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          a_q <= opa;
          b_q <= opb;
          trap_q <= trap_en;
          st <= S_CLASS;
        end
        S_CLASS: if (spec) begin
          is_special  <= 1'b1;
          special_val <= (sinv && trap_q) ? '0 : sval;
          inv_flag    <= sinv & ~trap_q;
          inv_trap    <= sinv & trap_q;
          sign_o      <= sgn;
          exp_o       <= '0;
          mant_o      <= '0;
          guard_o     <= 1'b0;
          sticky_o    <= 1'b0;
          done        <= 1'b1;
          st          <= S_IDLE;
        end else begin
          ma <= (ea != '0) ? {1'b1, fa} : {fa, 1'b0};
          mb <= (eb != '0) ? {1'b1, fb} : {fb, 1'b0};
          xe <= XW'({3'b000, ea}) + XW'({3'b000, eb}) - XW'(BIAS);
          st <= S_NORM;
        end
        S_NORM: if (!ma[MW-1]) begin
          ma <= ma << 1;
          xe <= xe - XW'(1);
        end else if (!mb[MW-1]) begin
          mb <= mb << 1;
          xe <= xe - XW'(1);
        end else begin
          mc  <= AW'(mb) << GB;
          mp  <= PW'(ma);
          acc <= '0;
          stk <= 1'b0;
          cnt <= '0;
          st  <= S_MUL;
        end
        S_MUL: begin
          stk <= stk | (|acc[3:0]);
          acc <= (acc >> 4) + addend;
          mp  <= mp >> 4;
          cnt <= cnt + CW'(1);
          if (cnt == CW'(STEPS - 1)) st <= S_ADJ;
        end
        S_ADJ: begin
          if (acc[LEAD]) xe <= xe + XW'(1);
          else acc <= acc << 1;
          st <= S_FIN;
        end
        S_FIN: if (!acc[LEAD]) begin
          acc <= acc << 1;
          xe  <= xe - XW'(1);
        end else begin
          is_special  <= 1'b0;
          special_val <= '0;
          inv_flag    <= 1'b0;
          inv_trap    <= 1'b0;
          sign_o      <= sgn;
          exp_o       <= xe;
          mant_o      <= acc[LEAD -: MW];
          guard_o     <= acc[LEAD-MW];
          sticky_o    <= stk | (|acc[LEAD-MW-1:0]);
          done        <= 1'b1;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmul_seq_chk.sv
module dmul_seq_chk #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           is_special,
  input logic [EW+FW:0] special_val,
  input logic           inv_flag,
  input logic           inv_trap,
  input logic [FW:0]    mant_o,
  input logic           guard_o,
  input logic           sticky_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && inv_trap) |-> (!inv_flag && is_special && special_val == '0)); // R3
  AST_HIDDEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_special) |-> mant_o[FW]); // R6
  AST_SPECIAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_special) |-> (mant_o == '0 && !guard_o && !sticky_o)); // R5
endmodule

bind dmul_seq dmul_seq_chk #(.EW(EW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .is_special(is_special),
  .special_val(special_val), .inv_flag(inv_flag), .inv_trap(inv_trap),
  .mant_o(mant_o), .guard_o(guard_o), .sticky_o(sticky_o)
);

// File: tb/dmul_seq_bench.sv
module dmul_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic trap_en = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic busy, done, is_special, inv_flag, inv_trap, sign_o, guard_o, sticky_o;
  logic [63:0] special_val;
  logic signed [13:0] exp_o;
  logic [52:0] mant_o;

  int n_tests = 0;
  int n_fail = 0;

  logic [63:0] r_val; logic r_sp, r_inv, r_trp, r_sgn, r_g, r_s; int r_exp; logic [52:0] r_mant;
  logic [63:0] e_val; logic e_sp, e_inv, e_trp, e_sgn, e_g, e_s; int e_exp; logic [52:0] e_mant;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmul_seq u_dmul_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .trap_en(trap_en), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .is_special(is_special), .special_val(special_val),
    .inv_flag(inv_flag), .inv_trap(inv_trap), .sign_o(sign_o), .exp_o(exp_o),
    .mant_o(mant_o), .guard_o(guard_o), .sticky_o(sticky_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic norm_in(input logic [63:0] v, output logic [52:0] m, output int x);
    x = int'(v[62:52]);
    if (x != 0) m = {1'b1, v[51:0]};
    else begin
      m = {1'b0, v[51:0]};
      x = 1;
      while (!m[52]) begin m = m << 1; x--; end
    end
  endtask

  task automatic ref_mul(input logic [63:0] a, input logic [63:0] b, input logic t);
    logic an, bn, ai, bi, as_, bs_, az, bz, inv, sp;
    logic [63:0] qa, qb, v, infv;
    logic [52:0] m1, m2;
    int x1, x2;
    logic [105:0] p;
    an = (&a[62:52]) && (|a[51:0]);  bn = (&b[62:52]) && (|b[51:0]);
    ai = (&a[62:52]) && !(|a[51:0]); bi = (&b[62:52]) && !(|b[51:0]);
    as_ = an && !a[51]; bs_ = bn && !b[51];
    az = (a[62:0] == 0); bz = (b[62:0] == 0);
    qa = a | 64'h0008000000000000; qb = b | 64'h0008000000000000;
    e_sgn = a[63] ^ b[63];
    infv = {e_sgn, 11'h7FF, 52'h0};
    inv = 1'b0; sp = 1'b1; v = '0;
    if (an) begin
      if (as_) begin inv = 1'b1; v = qa; end
      else if (bs_) begin inv = 1'b1; v = qb; end
      else v = a;
    end else if (bn) begin
      inv = bs_; v = qb;
    end else if ((ai && bz) || (bi && az)) begin
      inv = 1'b1; v = 64'h7FF8000000000000;
    end else if (ai || bi) v = infv;
    else if (az || bz) v = {e_sgn, 63'h0};
    else sp = 1'b0;
    e_sp = sp; e_inv = inv && !t; e_trp = inv && t;
    e_val = (inv && t) ? 64'h0 : v;
    e_exp = 0; e_mant = '0; e_g = 1'b0; e_s = 1'b0;
    if (!sp) begin
      norm_in(a, m1, x1);
      norm_in(b, m2, x2);
      p = {53'h0, m1} * {53'h0, m2};
      e_exp = x1 + x2 - 1023;
      if (p[105]) begin
        e_exp++; e_mant = p[105:53]; e_g = p[52]; e_s = |p[51:0];
      end else begin
        e_mant = p[104:52]; e_g = p[51]; e_s = |p[50:0];
      end
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic t, output int lat);
    @(negedge clk);
    opa = a; opb = b; trap_en = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    if (!done) chk("R9", "timeout waiting for done", 64'h0, 64'h1);
    r_val = special_val; r_sp = is_special; r_inv = inv_flag; r_trp = inv_trap;
    r_sgn = sign_o; r_exp = int'(exp_o); r_mant = mant_o; r_g = guard_o; r_s = sticky_o;
    @(negedge clk);
    chk("R9", "done one cycle", {63'h0, done}, 64'h0);
  endtask

  task automatic mul_check(input string req, input logic [63:0] a, input logic [63:0] b, input logic t, output int lat);
    run_op(a, b, t, lat);
    ref_mul(a, b, t);
    chk(req, "is_special", {63'h0, r_sp}, {63'h0, e_sp});
    chk(req, "special_val", r_val, e_val);
    chk(req, "inv_flag", {63'h0, r_inv}, {63'h0, e_inv});
    chk(req, "inv_trap", {63'h0, r_trp}, {63'h0, e_trp});
    chk("R1", "sign", {63'h0, r_sgn}, {63'h0, e_sgn});
    chk(req, "exponent", 64'(r_exp), 64'(e_exp));
    chk(req, "mantissa", {11'h0, r_mant}, {11'h0, e_mant});
    chk(req, "guard", {63'h0, r_g}, {63'h0, e_g});
    chk(req, "sticky", {63'h0, r_s}, {63'h0, e_s});
  endtask

  task automatic t_reset;
    chk("R9", "busy after reset", {63'h0, busy}, 64'h0);
    chk("R9", "done after reset", {63'h0, done}, 64'h0);
    chk("R9", "is_special after reset", {63'h0, is_special}, 64'h0);
  endtask

  task automatic t_basic;
    int lat;
    mul_check("R6", 64'h3FF8000000000000, 64'h4000000000000000, 1'b0, lat);
    chk("R10", "normal latency", 64'(lat), 64'd19);
    chk("R6", "exp below-2 product", 64'(r_exp), 64'd1024);
    mul_check("R6", 64'h4008000000000000, 64'h4008000000000000, 1'b0, lat);
    chk("R6", "exp at-least-2 product", 64'(r_exp), 64'd1026);
    mul_check("R1", 64'hBFF8000000000000, 64'h4008000000000000, 1'b0, lat);
    chk("R1", "negative sign", {63'h0, r_sgn}, 64'h1);
    mul_check("R1", 64'hC000000000000000, 64'hC010000000000000, 1'b0, lat);
  endtask

  task automatic t_inexact;
    int lat;
    mul_check("R8", 64'h3FF0000000000001, 64'h3FF0000000000003, 1'b0, lat);
    mul_check("R8", 64'h3FF5555555555555, 64'h4008000000000000, 1'b0, lat);
    mul_check("R8", 64'h3FFFFFFFFFFFFFFF, 64'h3FFFFFFFFFFFFFFF, 1'b0, lat);
    mul_check("R8", 64'h400921FB54442D18, 64'h4005BF0A8B145769, 1'b0, lat);
  endtask

  task automatic t_subnormal;
    int lat;
    mul_check("R7", 64'h0000000000000001, 64'h3FF0000000000000, 1'b0, lat);
    chk("R7", "smallest subnormal exp", 64'(r_exp), 64'(-51));
    mul_check("R7", 64'h3FF8000000000000, 64'h800FFFFFFFFFFFFF, 1'b0, lat);
    mul_check("R7", 64'h000FFFFFFFFFFFFF, 64'h0000000000000003, 1'b0, lat);
  endtask

  task automatic t_infzero;
    int lat;
    mul_check("R2", 64'h7FF0000000000000, 64'h0000000000000000, 1'b0, lat);
    chk("R2", "inf*0 qnan", r_val, 64'h7FF8000000000000);
    chk("R10", "special latency", 64'(lat), 64'd2);
    mul_check("R2", 64'h8000000000000000, 64'hFFF0000000000000, 1'b0, lat);
    chk("R2", "0*inf invalid", {63'h0, r_inv}, 64'h1);
    mul_check("R3", 64'h7FF0000000000000, 64'h0000000000000000, 1'b1, lat);
    chk("R3", "trap raised", {63'h0, r_trp}, 64'h1);
    mul_check("R3", 64'h7FF4000000000000, 64'h3FF0000000000000, 1'b1, lat);
  endtask

  task automatic t_nan;
    int lat;
    mul_check("R4", 64'hFFF0000000000123, 64'h7FF0000000000456, 1'b0, lat);
    chk("R4", "snan A first", r_val, 64'hFFF8000000000123);
    mul_check("R4", 64'h7FF8000000000001, 64'hFFF0000000000456, 1'b0, lat);
    chk("R4", "snan B over qnan A", r_val, 64'hFFF8000000000456);
    mul_check("R4", 64'h7FF8000000000001, 64'h7FF8000000000777, 1'b0, lat);
    chk("R4", "qnan A kept", r_val, 64'h7FF8000000000001);
    mul_check("R4", 64'h4000000000000000, 64'hFFF8000000000999, 1'b0, lat);
    mul_check("R4", 64'h7FF0000000000000, 64'h7FF0000000000005, 1'b0, lat);
    chk("R4", "inf*snan quieted", r_val, 64'h7FF8000000000005);
  endtask

  task automatic t_plain_special;
    int lat;
    mul_check("R5", 64'hFFF0000000000000, 64'h4000000000000000, 1'b0, lat);
    chk("R5", "neg inf", r_val, 64'hFFF0000000000000);
    mul_check("R5", 64'h0000000000000000, 64'hC014000000000000, 1'b0, lat);
    chk("R5", "neg zero", r_val, 64'h8000000000000000);
    mul_check("R5", 64'h0000000000000001, 64'h7FF0000000000000, 1'b0, lat);
  endtask

  task automatic t_busy;
    int lat;
    @(negedge clk);
    opa = 64'h3FF8000000000000; opb = 64'h4000000000000000; trap_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    opa = 64'h7FF0000000000000; opb = 64'h0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9", "busy during run", {63'h0, busy}, 64'h1);
    lat = 0;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    chk("R9", "first result kept", {63'h0, is_special}, 64'h0);
    chk("R9", "first mantissa kept", {11'h0, mant_o}, {11'h0, 53'h18000000000000});
    @(negedge clk);
    chk("R9", "no second done", {63'h0, done | busy}, 64'h0);
  endtask

  task automatic t_random;
    logic [63:0] x = 64'h9E3779B97F4A7C15;
    logic [63:0] a;
    int lat;
    for (int k = 0; k < 40; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      a = x;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      if (k % 4 == 0) a[62:52] = 11'h3FF;
      mul_check("R8", a, x, 1'b0, lat);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_inexact();
    t_subnormal();
    t_infzero();
    t_nan();
    t_plain_special();
    t_busy();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule